// File: doc/BRIEF.md
# Stereo Integer-Sample Audio Delay Line

This block delays the two channels of a continuous stereo audio stream by whole numbers of samples. Each channel has its own delay setting. Audio arrives as 32-bit words on an AXI-Stream slave port. The right sample sits in the upper half of each word and the left sample in the lower half. Delayed words leave on an AXI-Stream master port. Every accepted word appears at the output exactly one clock later, whatever the delay settings are.

Each channel keeps its past samples in a block-RAM style circular buffer of `DEPTH` entries. One shared write pointer moves forward by one for each accepted word. An AXI-Lite register slave holds three settings: an enable bit, the left delay and the right delay. Delay values are saturated into the legal range as they are written, so every read address stays inside the buffer.

When enable is cleared, the stage is frozen. Input words pass straight through with the same one-clock timing, and the buffers and the pointer stay untouched. When enable is set again, delaying resumes from the preserved history.

Top module: `stereo_delay_line`

## Requirements
- R1: Stream bits [15:0] carry the signed left sample and bits [31:16] carry the signed right sample, on both the input and the output words.
- R2: Each accepted input word produces exactly one output word, with m_tvalid high one clock after the accepting edge. m_tlast equals the accepted s_tlast. Words stay in order and none is lost.
- R3: While enabled, the left output equals the left input from DL accepted words earlier, and the right output equals the right input from DR accepted words earlier. DL and DR are set independently.
- R4: A delay of 0 returns the sample of the same accepted word.
- R5: Writing a delay register keeps only data bits [DW-1:0] (DW = clog2(DEPTH); 10 with DEPTH = 1000) and ignores the bits above. A field above DEPTH-1 saturates to DEPTH-1. Reading a delay register returns the stored, saturated value.
- R6: If fewer than D words have been written into the buffer since reset, a channel with delay D outputs 0.
- R7: While m_tvalid is high and m_tready is low, s_tready is low and m_tdata and m_tlast hold their values.
- R8: With the control register bit 0 (enable) at 0, the output equals the undelayed input. No buffer entry is written and the write pointer holds. Samples passed through while frozen never appear in later delayed output.
- R9: A new delay value applies from the first word accepted after the register write completes.
- R10: A delay of DEPTH-1 returns the correct sample once the write pointer has wrapped around the buffer.
- R11: The registers sit at byte offsets 0x0 (control, bit 0 enable), 0x4 (left delay) and 0x8 (right delay). After reset, enable is 1 and both delays are 0. Every write and read completes with response OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 32 | Input stereo word |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Stage can accept a word |
| s_tlast | input | 1 | Input packet end marker |
| m_tdata | output | 32 | Delayed stereo word |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream accepts the word |
| m_tlast | output | 1 | Output packet end marker |
| cfg_awaddr | input | 4 | Register write byte address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address accepted |
| cfg_wdata | input | 32 | Register write data |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data accepted |
| cfg_bresp | output | 2 | Write response |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response taken |
| cfg_araddr | input | 4 | Register read byte address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address accepted |
| cfg_rdata | output | 32 | Register read data |
| cfg_rresp | output | 2 | Read response |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data taken |

## Verification
Two events can fall in the same clock. In the first, a new input word is accepted in the very edge where the downstream takes the held output word. In the second, a stall makes the stage refuse input while a word sits in its output register. The bench provokes both by driving m_tready from a pseudo-random pattern during long random streams, including a full buffer wrap at the maximum delay, and by holding a forced stall for several clocks. A scoreboard predicts every output word from its own model of the history, delays and freeze state, and checks it for value, tlast and order. A word dropped or duplicated at the refill/drain boundary would show up as a mismatch or as a leftover queue entry.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int SMP_W   = 16;
    localparam int CFG_AW  = 4;

    typedef struct packed {
        logic signed [SMP_W-1:0] right;
        logic signed [SMP_W-1:0] left;
    } stereo_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DLY_L = 2'd1,
        SEL_DLY_R = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [CFG_AW-1:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        return reg_sel_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/sdl_regs.sv
module sdl_regs
    import sdl_pkg::*;
#(
    parameter int DEPTH = 1000,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [CFG_AW-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              enable,
    output logic [DW-1:0]     dly_l,
    output logic [DW-1:0]     dly_r
);

    localparam logic [DW-1:0] DMAX = DW'(DEPTH - 1);

    function automatic logic [DW-1:0] saturate(input logic [DW-1:0] f);
        return (f > DMAX) ? DMAX : f;
    endfunction

    logic do_wr, do_rd;
    logic unused_hi;

    assign unused_hi = ^wdata[31:DW];
    assign do_wr     = awvalid && wvalid && !bvalid;
    assign awready   = do_wr;
    assign wready    = do_wr;
    assign arready   = !rvalid;
    assign do_rd     = arvalid && arready;
    assign bresp     = 2'b00;
    assign rresp     = 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b1;
            dly_l  <= '0;
            dly_r  <= '0;
            bvalid <= 1'b0;
        end else begin
            if (do_wr) begin
                bvalid <= 1'b1;
                case (decode_addr(awaddr))
                    SEL_CTRL:  enable <= wdata[0];
                    SEL_DLY_L: dly_l  <= saturate(wdata[DW-1:0]);
                    SEL_DLY_R: dly_r  <= saturate(wdata[DW-1:0]);
                    default: ;
                endcase
            end else if (bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (do_rd) begin
            rvalid <= 1'b1;
            case (decode_addr(araddr))
                SEL_CTRL:  rdata <= {31'd0, enable};
                SEL_DLY_L: rdata <= 32'(dly_l);
                SEL_DLY_R: rdata <= 32'(dly_r);
                default:   rdata <= '0;
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R5: stored delays never exceed the buffer's legal maximum
    p_dly_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (dly_l <= DMAX) && (dly_r <= DMAX));

    // R11: a pending write response is held until taken
    p_bresp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

endmodule

// File: rtl/sdl_chan.sv
module sdl_chan
    import sdl_pkg::*;
#(
    parameter int DEPTH = 1000,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc,
    input  logic                    en,
    input  logic [DW-1:0]           wptr,
    input  logic [DW-1:0]           fill,
    input  logic [DW-1:0]           dly,
    input  logic signed [SMP_W-1:0] din,
    output logic signed [SMP_W-1:0] dout
);

    localparam logic [DW:0] DEPTH_X = (DW+1)'(DEPTH);

    logic [SMP_W-1:0] mem [DEPTH];
    logic [DW:0]      sum;
    logic [DW-1:0]    raddr;

    always_comb begin
        sum = {1'b0, wptr} + DEPTH_X - {1'b0, dly};
        if (sum >= DEPTH_X) raddr = DW'(sum - DEPTH_X);
        else                raddr = sum[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (acc && en) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (acc) begin
            if (!en || dly == '0) dout <= din;
            else if (dly <= fill) dout <= mem[raddr];
            else                  dout <= '0;
        end
    end

    // R5: the read address always falls inside the buffer
    p_raddr_range_r5: assert property (@(posedge clk) disable iff (rst)
        {1'b0, raddr} < DEPTH_X);

    // R4: zero delay forwards the sample accepted in the same transfer
    p_zero_delay_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && en && dly == '0) |=> (dout == $past(din)));

endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line
    import sdl_pkg::*;
#(
    parameter int DEPTH = 1000,
    parameter int DW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    output logic [31:0]       m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    input  logic [CFG_AW-1:0] cfg_awaddr,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    output logic [1:0]        cfg_bresp,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    input  logic [CFG_AW-1:0] cfg_araddr,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        cfg_rresp,
    output logic              cfg_rvalid,
    input  logic              cfg_rready
);

    localparam int NCH = 2;
    localparam logic [DW-1:0] LAST_IDX = DW'(DEPTH - 1);

    logic          enable;
    logic [DW-1:0] dly_l, dly_r;
    logic [DW-1:0] wptr, fill;
    logic          acc, ov, olast;
    stereo_t       in_w, out_w;

    logic signed [SMP_W-1:0] din_a  [NCH];
    logic signed [SMP_W-1:0] dout_a [NCH];
    logic [DW-1:0]           dly_a  [NCH];

    sdl_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
        .wdata(cfg_wdata), .wvalid(cfg_wvalid), .wready(cfg_wready),
        .bresp(cfg_bresp), .bvalid(cfg_bvalid), .bready(cfg_bready),
        .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
        .rdata(cfg_rdata), .rresp(cfg_rresp), .rvalid(cfg_rvalid), .rready(cfg_rready),
        .enable(enable), .dly_l(dly_l), .dly_r(dly_r)
    );

    assign in_w     = stereo_t'(s_tdata);
    assign din_a[0] = in_w.left;
    assign din_a[1] = in_w.right;
    assign dly_a[0] = dly_l;
    assign dly_a[1] = dly_r;

    assign s_tready = !ov || m_tready;
    assign acc      = s_tvalid && s_tready;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            sdl_chan #(.DEPTH(DEPTH), .DW(DW)) u_chan (
                .clk(clk), .rst(rst), .acc(acc), .en(enable),
                .wptr(wptr), .fill(fill), .dly(dly_a[ch]),
                .din(din_a[ch]), .dout(dout_a[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            fill <= '0;
        end else if (acc && enable) begin
            wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            if (fill != LAST_IDX) fill <= fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ov    <= 1'b0;
            olast <= 1'b0;
        end else if (acc) begin
            ov    <= 1'b1;
            olast <= s_tlast;
        end else if (m_tready) begin
            ov    <= 1'b0;
        end
    end

    assign out_w.left  = dout_a[0];
    assign out_w.right = dout_a[1];
    assign m_tdata     = out_w;
    assign m_tvalid    = ov;
    assign m_tlast     = olast;

    // R7: a stalled output word blocks input and stays put
    p_stall_block_r7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |-> !s_tready);
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R2: one-cycle latency with tlast carried alongside
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> (m_tvalid && m_tlast == $past(s_tlast)));

    // R8: frozen transfers leave the write pointer untouched
    p_freeze_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && !enable) |=> $stable(wptr));

endmodule

// File: tb/tb_stereo_delay_line.sv
module tb_stereo_delay_line;

    localparam int DEPTH = 1000;
    localparam int DMAXV = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0;
    logic        s_tready;
    logic [31:0] m_tdata;
    logic        m_tvalid, m_tlast;
    logic        m_tready = 1'b1;
    logic [3:0]  cfg_awaddr = '0, cfg_araddr = '0;
    logic        cfg_awvalid = 1'b0, cfg_wvalid = 1'b0, cfg_arvalid = 1'b0;
    logic        cfg_bready = 1'b1, cfg_rready = 1'b1;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
    logic [1:0]  cfg_bresp, cfg_rresp;
    logic [31:0] cfg_rdata;

    always #10 clk = ~clk;

    stereo_delay_line dut (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .cfg_awaddr(cfg_awaddr), .cfg_awvalid(cfg_awvalid), .cfg_awready(cfg_awready),
        .cfg_wdata(cfg_wdata), .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready),
        .cfg_bresp(cfg_bresp), .cfg_bvalid(cfg_bvalid), .cfg_bready(cfg_bready),
        .cfg_araddr(cfg_araddr), .cfg_arvalid(cfg_arvalid), .cfg_arready(cfg_arready),
        .cfg_rdata(cfg_rdata), .cfg_rresp(cfg_rresp), .cfg_rvalid(cfg_rvalid),
        .cfg_rready(cfg_rready)
    );

    int    n_tests = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    int    bp_mode = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    logic [31:0] q_data[$];
    logic        q_last[$];
    string       q_tag[$];

    bit          m_en = 1'b1;
    int          m_dl = 0, m_dr = 0;
    logic [15:0] hl[$], hr[$];

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    function automatic int clampd(input logic [31:0] v);
        int f;
        f = int'(v[9:0]);
        return (f > DMAXV) ? DMAXV : f;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // model: expected word for one accepted input
    task automatic model_push(input logic [31:0] d, input bit last);
        logic [15:0] el, er;
        int n;
        n = hl.size();
        if (!m_en) begin
            el = d[15:0];
            er = d[31:16];
        end else begin
            el = (m_dl == 0) ? d[15:0]  : (m_dl <= n ? hl[n - m_dl] : 16'h0);
            er = (m_dr == 0) ? d[31:16] : (m_dr <= n ? hr[n - m_dr] : 16'h0);
            hl.push_back(d[15:0]);
            hr.push_back(d[31:16]);
        end
        q_data.push_back({er, el});
        q_last.push_back(last);
        q_tag.push_back(cur_tag);
    endtask

    // driver: call at a falling edge, returns at a falling edge
    task automatic send(input logic [31:0] d, input bit last);
        s_tdata  = d;
        s_tlast  = last;
        s_tvalid = 1'b1;
        forever begin
            #2;
            if (s_tready) begin
                model_push(d, last);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        s_tvalid = 1'b0;
    endtask

    task automatic send_rand(input int n, input int last_every);
        for (int i = 0; i < n; i++) begin
            lfsr = nxt(lfsr);
            send(lfsr, ((i + 1) % last_every) == 0);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_awaddr = a; cfg_wdata = d;
        cfg_awvalid = 1'b1; cfg_wvalid = 1'b1;
        forever begin
            #2;
            if (cfg_awready) break;
            @(negedge clk);
        end
        @(negedge clk);
        cfg_awvalid = 1'b0; cfg_wvalid = 1'b0;
        forever begin
            #2;
            if (cfg_bvalid) break;
            @(negedge clk);
        end
        check(cfg_bresp == 2'b00, "R11", "write response", 32'(cfg_bresp), 32'd0);
        @(negedge clk);
        if (a == 4'h0) m_en = d[0];
        if (a == 4'h4) m_dl = clampd(d);
        if (a == 4'h8) m_dr = clampd(d);
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
        cfg_araddr = a; cfg_arvalid = 1'b1;
        forever begin
            #2;
            if (cfg_arready) break;
            @(negedge clk);
        end
        @(negedge clk);
        cfg_arvalid = 1'b0;
        forever begin
            #2;
            if (cfg_rvalid) break;
            @(negedge clk);
        end
        d = cfg_rdata;
        check(cfg_rresp == 2'b00, "R11", "read response", 32'(cfg_rresp), 32'd0);
        @(negedge clk);
    endtask

    // downstream ready pattern
    initial begin
        logic [31:0] r = 32'h0BAD_F00D;
        forever begin
            @(negedge clk);
            r = nxt(r);
            case (bp_mode)
                0: m_tready = 1'b1;
                1: m_tready = r[3] | r[7];
                default: m_tready = 1'b0;
            endcase
        end
    end

    // monitor: pops one expected word per completed output transfer
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R2", "unexpected output word", m_tdata, 32'hx);
                end else begin
                    logic [31:0] ed;
                    logic        el;
                    string       et;
                    ed = q_data.pop_front();
                    el = q_last.pop_front();
                    et = q_tag.pop_front();
                    check(m_tdata == ed && m_tlast == el, et, "output word{data,last}",
                          {m_tdata[30:0], m_tlast}, {ed[30:0], el});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] rd, held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        #2;
        check(m_tvalid == 1'b0, "R11", "m_tvalid after reset", 32'(m_tvalid), 32'd0);
        check(s_tready == 1'b1, "R11", "s_tready after reset", 32'(s_tready), 32'd1);
        @(negedge clk);
        cfg_read(4'h0, rd); check(rd == 32'd1, "R11", "ctrl reset", rd, 32'd1);
        cfg_read(4'h4, rd); check(rd == 32'd0, "R11", "left delay reset", rd, 32'd0);
        cfg_read(4'h8, rd); check(rd == 32'd0, "R11", "right delay reset", rd, 32'd0);

        // R1/R4: pass-through with distinct halves
        cur_tag = "R1";
        send(32'h8001_7FFF, 1'b0);
        send(32'h1234_ABCD, 1'b1);
        cur_tag = "R4";
        send_rand(4, 2);

        // R2: output valid one clock after an accept from idle
        cur_tag = "R2";
        send(32'h0F0F_F0F0, 1'b1);
        #2;
        check(m_tvalid == 1'b1 && m_tlast == 1'b1, "R2", "valid/last one clock after accept",
              {30'd0, m_tvalid, m_tlast}, 32'd3);
        @(negedge clk);

        // R6: delays longer than the history output silence first
        cfg_write(4'h4, 32'd12);
        cfg_write(4'h8, 32'd9);
        cur_tag = "R6";
        send_rand(8, 4);

        // R3: independent delays under random backpressure
        cur_tag = "R3";
        bp_mode = 1;
        send_rand(40, 8);
        bp_mode = 0;

        // R9: delay change applies to the next accepted word
        cur_tag = "R9";
        cfg_write(4'h4, 32'd1);
        send_rand(5, 5);
        cfg_write(4'h4, 32'd0);
        cfg_write(4'h8, 32'd3);
        send_rand(5, 5);

        // R8: freeze passes through and leaves history untouched
        cur_tag = "R8";
        cfg_write(4'h4, 32'd2);
        cfg_write(4'h0, 32'd0);
        send_rand(6, 3);
        cfg_write(4'h0, 32'd1);
        send_rand(6, 3);

        // R7: forced stall
        repeat (3) @(negedge clk);
        bp_mode = 2;
        @(negedge clk);
        cur_tag = "R7";
        send(32'h5A5A_A5A5, 1'b1);
        #2;
        held = m_tdata;
        check(m_tvalid == 1'b1, "R7", "output held valid in stall", 32'(m_tvalid), 32'd1);
        check(s_tready == 1'b0, "R7", "s_tready low in stall", 32'(s_tready), 32'd0);
        s_tdata = 32'h1111_2222; s_tvalid = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        check(s_tready == 1'b0, "R7", "s_tready still low", 32'(s_tready), 32'd0);
        check(m_tdata == held && m_tvalid, "R7", "held word stable", m_tdata, held);
        s_tvalid = 1'b0;
        @(negedge clk);
        bp_mode = 0;
        send(32'h1111_2222, 1'b0);

        // R5: saturation and ignored upper bits
        cur_tag = "R5";
        cfg_write(4'h4, 32'h0000_0FFF);
        cfg_read(4'h4, rd); check(rd == 32'd999, "R5", "left delay saturated", rd, 32'd999);
        cfg_write(4'h8, 32'hFFFF_FC05);
        cfg_read(4'h8, rd); check(rd == 32'd5, "R5", "upper bits ignored", rd, 32'd5);
        send_rand(10, 5);

        // R10: maximum delay across a pointer wrap
        cur_tag = "R10";
        bp_mode = 1;
        send_rand(1100, 16);
        bp_mode = 0;

        repeat (6) @(negedge clk);
        check(q_data.size() == 0, "R2", "all expected words delivered",
              32'(q_data.size()), 32'd0);
        finish_run();
    end

endmodule